// File: doc/BRIEF.md
# Outstanding Transaction Issue Limiter

This block sits between a bus manager's request logic and the read and write address channels it drives toward a subordinate. It keeps one in-flight counter per direction. A read counts as in flight from its address handshake until the handshake of the read data beat that is flagged last. A write counts as in flight from its address handshake until its write response handshake. When a direction reaches its issue ceiling, the block stops new addresses in that direction by holding the downstream valid and the upstream ready low.

The ceiling is set at run time by `cfg_limit` and bounded by the synthesis parameter `MAX_OUT`. A ceiling of one gives strict issue-then-wait behaviour. Larger values let addresses go out on consecutive cycles while earlier data is still returning, which hides the subordinate's latency. A downstream valid that has been raised is never withdrawn by the gating. A response arriving with nothing in flight sets a sticky error flag.

Top module: `txn_issue_limiter`

## Requirements
- R1: The read count rises by one after a cycle with `m_arvalid & m_arready`. It falls by one after a cycle with `rvalid & rready & rlast`. A read beat with `rlast=0` leaves the count unchanged.
- R2: The write count rises by one after a cycle with `m_awvalid & m_awready` and falls by one after a cycle with `bvalid & bready`.
- R3: While a direction's count is at or above the effective ceiling and no offer is pending, that direction's downstream valid and upstream ready are 0. Its stalled output equals the upstream valid in that state, and is 0 otherwise.
- R4: The effective ceiling is `cfg_limit` when that lies in 1..`MAX_OUT`. The value 0 acts as 1, and any value above `MAX_OUT` acts as `MAX_OUT`. With a ceiling of 1, the next address is only offered in the cycle after the completing handshake.
- R5: Below the ceiling, the downstream valid equals the upstream valid in the same cycle and the upstream ready equals the downstream ready. Addresses are therefore accepted on consecutive cycles.
- R6: The read and write counts are independent. Traffic on one direction never changes the other direction's count or gating.
- R7: An address handshake and a completing handshake in the same cycle on one direction leave that count unchanged.
- R8: Once a downstream valid has been shown without ready, it stays high in the following cycles while the upstream valid stays high, even if the ceiling is lowered.
- R9: A read beat handshake while the read count is 0, or a write response handshake while the write count is 0, sets `proto_err`. The flag stays at 1 until reset, and the count stays at 0.
- R10: After reset, both counts are 0 and `proto_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_limit | input | CFG_W | Requested in-flight ceiling per direction |
| src_arvalid | input | 1 | Read address offered by the request source |
| src_arready | output | 1 | Read address taken from the request source |
| m_arvalid | output | 1 | Gated read address valid toward the subordinate |
| m_arready | input | 1 | Subordinate read address ready |
| rvalid | input | 1 | Read data valid (observed) |
| rready | input | 1 | Read data ready (observed) |
| rlast | input | 1 | Final read beat marker (observed) |
| src_awvalid | input | 1 | Write address offered by the request source |
| src_awready | output | 1 | Write address taken from the request source |
| m_awvalid | output | 1 | Gated write address valid toward the subordinate |
| m_awready | input | 1 | Subordinate write address ready |
| bvalid | input | 1 | Write response valid (observed) |
| bready | input | 1 | Write response ready (observed) |
| rd_inflight | output | CW | Reads currently in flight |
| wr_inflight | output | CW | Writes currently in flight |
| rd_stalled | output | 1 | Read address held back by the ceiling this cycle |
| wr_stalled | output | 1 | Write address held back by the ceiling this cycle |
| proto_err | output | 1 | Sticky stray-response flag |

## Verification
Two events can land in the same cycle on one direction: accepting a new address and retiring the oldest transaction. The bench provokes this by asserting the address handshake together with a last read beat while below the ceiling. It then judges the count one edge later, expecting no change. The bench also pairs a retirement with a request that arrives exactly at the ceiling, and expects the request to stay gated in that cycle and to go out in the next.

// File: rtl/txn_lim_pkg.sv
package txn_lim_pkg;

    typedef enum int unsigned {
        CH_READ  = 0,
        CH_WRITE = 1
    } chan_kind_e;

    localparam int unsigned NUM_CHAN = 2;

    // Per-cycle events seen by one direction's counter.
    typedef struct packed {
        logic issue;   // address handshake
        logic retire;  // completing handshake
        logic stray;   // response with nothing in flight
    } chan_evt_t;

    // Map the requested ceiling onto 1..cap.
    function automatic int unsigned clamp_limit(int unsigned req, int unsigned cap);
        if (req == 0)  return 1;
        if (req > cap) return cap;
        return req;
    endfunction

endpackage

// File: rtl/lim_evt_decode.sv
module lim_evt_decode
    import txn_lim_pkg::*;
#(
    parameter chan_kind_e KIND = CH_READ
) (
    input  logic      addr_valid,
    input  logic      addr_ready,
    input  logic      rsp_valid,
    input  logic      rsp_ready,
    input  logic      rsp_last,
    input  logic      cnt_zero,
    output chan_evt_t evt
);
    logic rsp_hs;
    logic final_beat;

    assign rsp_hs = rsp_valid & rsp_ready;

    generate
        if (KIND == CH_READ) begin : g_rd
            assign final_beat = rsp_last;
        end else begin : g_wr
            // A write response is always a single completing beat.
            logic unused_last;
            assign unused_last = rsp_last;
            assign final_beat  = 1'b1;
        end
    endgenerate

    always_comb begin
        evt.issue  = addr_valid & addr_ready;
        evt.retire = rsp_hs & final_beat & ~cnt_zero;
        evt.stray  = rsp_hs & cnt_zero;
    end
endmodule

// File: rtl/lim_inflight_ctr.sv
module lim_inflight_ctr
    import txn_lim_pkg::*;
#(
    parameter int unsigned CAP = 8,
    localparam int unsigned CW = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_evt_t     evt,
    output logic [CW-1:0] count
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case ({evt.issue, evt.retire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(CAP));  // R3
    AST_NET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (evt.issue && evt.retire) |=> count_q == $past(count_q));  // R7
    AST_RETIRE_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!evt.issue && evt.retire) |=> count_q == $past(count_q) - 1'b1);  // R1
    AST_STRAY_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (evt.stray && !evt.issue) |=> count_q == '0);  // R9
endmodule

// File: rtl/lim_issue_gate.sv
module lim_issue_gate #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] limit,
    input  logic          up_valid,
    output logic          up_ready,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          stalled
);
    logic held_q;
    logic open;

    // An offer already on the wire stays allowed until it is taken.
    assign open     = (count < limit) | held_q;
    assign dn_valid = up_valid & open;
    assign up_ready = dn_ready & open;
    assign stalled  = up_valid & ~open;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= dn_valid & ~dn_ready;
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (!up_valid || dn_valid));  // R8
    AST_CLOSED_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (count >= limit && !held_q) |-> (!dn_valid && !up_ready));  // R3
endmodule

// File: rtl/txn_issue_limiter.sv
module txn_issue_limiter
    import txn_lim_pkg::*;
#(
    parameter int unsigned MAX_OUT = 8,
    localparam int unsigned CW    = $clog2(MAX_OUT + 1),
    localparam int unsigned CFG_W = CW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_limit,
    input  logic             src_arvalid,
    output logic             src_arready,
    output logic             m_arvalid,
    input  logic             m_arready,
    input  logic             rvalid,
    input  logic             rready,
    input  logic             rlast,
    input  logic             src_awvalid,
    output logic             src_awready,
    output logic             m_awvalid,
    input  logic             m_awready,
    input  logic             bvalid,
    input  logic             bready,
    output logic [CW-1:0]    rd_inflight,
    output logic [CW-1:0]    wr_inflight,
    output logic             rd_stalled,
    output logic             wr_stalled,
    output logic             proto_err
);
    logic [CW-1:0] eff_limit;

    logic [NUM_CHAN-1:0]         up_v, up_r, dn_v, dn_r;
    logic [NUM_CHAN-1:0]         rsp_v, rsp_r, rsp_l, stall;
    logic [NUM_CHAN-1:0][CW-1:0] cnt;
    chan_evt_t [NUM_CHAN-1:0]    evt;
    logic                        err_q;

    assign eff_limit = CW'(clamp_limit(int'(cfg_limit), MAX_OUT));

    assign up_v  = {src_awvalid, src_arvalid};
    assign dn_r  = {m_awready,   m_arready};
    assign rsp_v = {bvalid,      rvalid};
    assign rsp_r = {bready,      rready};
    assign rsp_l = {1'b1,        rlast};

    generate
        for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
            localparam chan_kind_e KIND = chan_kind_e'(c);

            lim_issue_gate #(.CW(CW)) i_gate (
                .clk      (clk),
                .rst      (rst),
                .count    (cnt[c]),
                .limit    (eff_limit),
                .up_valid (up_v[c]),
                .up_ready (up_r[c]),
                .dn_valid (dn_v[c]),
                .dn_ready (dn_r[c]),
                .stalled  (stall[c])
            );

            lim_evt_decode #(.KIND(KIND)) i_dec (
                .addr_valid (dn_v[c]),
                .addr_ready (dn_r[c]),
                .rsp_valid  (rsp_v[c]),
                .rsp_ready  (rsp_r[c]),
                .rsp_last   (rsp_l[c]),
                .cnt_zero   (cnt[c] == '0),
                .evt        (evt[c])
            );

            lim_inflight_ctr #(.CAP(MAX_OUT)) i_ctr (
                .clk   (clk),
                .rst   (rst),
                .evt   (evt[c]),
                .count (cnt[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | evt[CH_READ].stray | evt[CH_WRITE].stray;
    end

    assign src_arready = up_r[CH_READ];
    assign src_awready = up_r[CH_WRITE];
    assign m_arvalid   = dn_v[CH_READ];
    assign m_awvalid   = dn_v[CH_WRITE];
    assign rd_inflight = cnt[CH_READ];
    assign wr_inflight = cnt[CH_WRITE];
    assign rd_stalled  = stall[CH_READ];
    assign wr_stalled  = stall[CH_WRITE];
    assign proto_err   = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(err_q) |-> err_q);  // R9
    AST_WR_INDEPENDENT: assert property (@(posedge clk) disable iff (rst)
        (!(m_awvalid && m_awready) && !(bvalid && bready)) |=> $stable(wr_inflight));  // R6
endmodule

// File: tb/test_txn_issue_limiter.sv
module test_txn_issue_limiter;
    localparam int unsigned MAX_OUT = 8;
    localparam int unsigned CW      = $clog2(MAX_OUT + 1);
    localparam int unsigned CFG_W   = CW + 1;

    typedef struct packed {
        logic [4:0] lim;
        logic ar, arr, rv, rl;
        logic aw, awr, bv;
        logic e_arv, e_awv;
        logic [3:0] e_rd, e_wr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // lim   ar   arr  rv   rl   aw   awr  bv  e_arv e_awv e_rd e_wr
        '{5'd2, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,4'd0}, // R5 first issue
        '{5'd2, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2,4'd0}, // R5 back-to-back
        '{5'd2, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,4'd0}, // R3 at ceiling
        '{5'd2, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,4'd0}, // R1 non-last beat
        '{5'd2, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,4'd0}, // R3 retire while gated
        '{5'd2, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,4'd0}, // R7 issue+retire
        '{5'd2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'd1,4'd1}, // R6 write issue
        '{5'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,4'd1}, // R4 depth one
        '{5'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd1,4'd0}, // R2 write retire
        '{5'd1, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0}, // R1 read retire
        '{5'd0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,4'd0}, // R4 zero acts as one
        '{5'd0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,4'd0}, // R4 zero blocks
        '{5'd15,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2,4'd0}  // R4 clamp to MAX_OUT
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CFG_W-1:0] cfg_limit = '0;
    logic src_arvalid = 0, m_arready = 0, rvalid = 0, rready = 1, rlast = 0;
    logic src_awvalid = 0, m_awready = 0, bvalid = 0, bready = 1;
    logic src_arready, m_arvalid, src_awready, m_awvalid;
    logic [CW-1:0] rd_inflight, wr_inflight;
    logic rd_stalled, wr_stalled, proto_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    txn_issue_limiter #(.MAX_OUT(MAX_OUT)) i_txn_issue_limiter (
        .clk(clk), .rst(rst), .cfg_limit(cfg_limit),
        .src_arvalid(src_arvalid), .src_arready(src_arready),
        .m_arvalid(m_arvalid), .m_arready(m_arready),
        .rvalid(rvalid), .rready(rready), .rlast(rlast),
        .src_awvalid(src_awvalid), .src_awready(src_awready),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .bvalid(bvalid), .bready(bready),
        .rd_inflight(rd_inflight), .wr_inflight(wr_inflight),
        .rd_stalled(rd_stalled), .wr_stalled(wr_stalled),
        .proto_err(proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic drive(input logic [4:0] lim, input logic ar, arr, rv, rl,
                         input logic aw, awr, bv);
        cfg_limit   = lim;
        src_arvalid = ar;  m_arready = arr; rvalid = rv; rlast = rl;
        src_awvalid = aw;  m_awready = awr; bvalid = bv;
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive(5'd0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        #1;
        chk("R10 rd count after reset", rd_inflight, 0);
        chk("R10 wr count after reset", wr_inflight, 0);
        chk("R10 err after reset", proto_err, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            @(negedge clk);
            drive(v.lim, v.ar, v.arr, v.rv, v.rl, v.aw, v.awr, v.bv);
            #5;
            chk($sformatf("R3/R5 m_arvalid row %0d", i), m_arvalid, v.e_arv);
            chk($sformatf("R3/R5 m_awvalid row %0d", i), m_awvalid, v.e_awv);
            chk($sformatf("R5 src_arready row %0d", i), src_arready, v.e_arv & v.arr);
            chk($sformatf("R3 rd_stalled row %0d", i), rd_stalled, v.ar & ~v.e_arv);
            chk($sformatf("R3 wr_stalled row %0d", i), wr_stalled, v.aw & ~v.e_awv);
            @(posedge clk);
            #1;
            chk($sformatf("R1/R7 rd count row %0d", i), rd_inflight, int'(v.e_rd));
            chk($sformatf("R2/R6 wr count row %0d", i), wr_inflight, int'(v.e_wr));
        end

        // R8: offer pending when the ceiling drops stays on the wire
        do_reset();
        drive(5'd2, 1, 1, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R8 setup rd count", rd_inflight, 1);
        @(negedge clk);
        drive(5'd2, 1, 0, 0, 0, 0, 0, 0);
        #5;
        chk("R8 offer shown", m_arvalid, 1);
        chk("R8 no ready upstream", src_arready, 0);
        @(negedge clk);
        drive(5'd1, 1, 0, 0, 0, 0, 0, 0);
        #5;
        chk("R8 valid held after ceiling drop", m_arvalid, 1);
        chk("R8 not reported stalled", rd_stalled, 0);
        @(negedge clk);
        drive(5'd1, 1, 1, 0, 0, 0, 0, 0);
        #5;
        chk("R8 pending offer accepted", src_arready, 1);
        @(posedge clk); #1;
        chk("R8 rd count after accept", rd_inflight, 2);
        @(negedge clk);
        drive(5'd1, 1, 1, 0, 0, 0, 0, 0);
        #5;
        chk("R3 gated after held offer", m_arvalid, 0);
        chk("R3 stalled after held offer", rd_stalled, 1);

        // R9: stray write response
        @(negedge clk);
        drive(5'd1, 0, 0, 0, 0, 0, 0, 1);
        @(posedge clk); #1;
        chk("R9 err set by stray B", proto_err, 1);
        chk("R9 wr count stays zero", wr_inflight, 0);
        chk("R6 rd count untouched", rd_inflight, 2);
        @(negedge clk);
        drive(5'd1, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R9 err sticky", proto_err, 1);

        // R9: stray read beat after reset
        do_reset();
        drive(5'd4, 0, 0, 1, 0, 0, 0, 0);
        #1;
        chk("R10 err cleared by reset", proto_err, 0);
        @(posedge clk); #1;
        chk("R9 err set by stray R", proto_err, 1);
        chk("R9 rd count stays zero", rd_inflight, 0);

        finish_run();
    end
endmodule